// File: doc/BRIEF.md
# Mainboard Interrupt Source Collector

This block gathers the single-cycle event pulses of the mainboard's interrupt sources into latched flags and presents them as level interrupt requests: one line for the timer tick, one line shared by the timer-channel-2, serial and parallel sources, and one line shared by the DMA terminal-count, keyboard transmit, keyboard receive, floppy controller and math coprocessor sources. Each flag is armed by the rising edge of its event and stays set until software touches the register offset that clears it, or until the owning device acknowledges it through a per-source clear pulse.

Alongside the interrupt flags it keeps a parity-error flag and an I/O-error flag, which can raise a non-maskable interrupt when software has enabled it. It also keeps two sticky flags that record any transition on the floppy drives' change-line levels, and a diagnostic LED driven by side-effect reads. Software sees all of this through a small register port: an offset, a read strobe, a write strobe and write data, with combinational read data. Reads and writes of several offsets have side effects. One status register mixes active-low and active-high bits.

Top module: `mb_irq_collector`

## Requirements
- R1: After reset every flag is clear, all interrupt outputs, `nmi_o` and `led_o` are low, offset 22h reads 0Fh, offset E0h reads 03h (with both change-line levels low), and offset FEh reads 00h.
- R2: Each of the eight source flags (index 0 timer channel 2, 1 serial, 2 parallel, 3 DMA terminal count, 4 keyboard transmit, 5 keyboard receive, 6 floppy controller, 7 coprocessor) is set by the clock edge that first sees its event input high after it was low. An event held high sets the flag once.
- R3: A read of offset 22h returns the source flags at their indices. Bits 0 to 3 read 0 when pending and 1 when idle. Bits 4 to 7 read 1 when pending and 0 when idle.
- R4: `irq1_o` is high exactly when any of flags 0 to 2 is set. `irq2_o` is high exactly when any of flags 3 to 7 is set.
- R5: A read of E2h clears flag 0. A read of E6h clears flag 3 only. A write of E6h clears flag 4 only. A pulse on `src_ack_i[k]` clears flag k.
- R6: When an event rising edge and a clear of the same flag fall in the same cycle, the flag ends set.
- R7: `irq0_o` is set by a rising edge of `tick_i` and cleared by any write of offset E0h. Reads of E0h leave it unchanged.
- R8: A read of offset E0h returns bit 0 = NOT parity flag, bit 1 = NOT I/O-error flag, bit 2 = 0, bit 3 = flag 6, bits 4 and 5 = change flags of drives 0 and 1, bits 6 and 7 = live change-line levels of drives 0 and 1.
- R9: A change flag sets on any transition of its drive's change-line level. A write of offset 00h clears the drive-0 flag when data bit 2 is set and the drive-1 flag when data bit 3 is set. Other data bits have no effect on them.
- R10: The parity flag and the I/O-error flag set on rising edges of their inputs. A write of EEh clears the parity flag. The I/O-error flag is cleared only by reset.
- R11: A write of E2h loads data bit 0 as the NMI enable. `nmi_o` is high when the enable is set and the parity flag or the I/O-error flag is set.
- R12: A read of E4h turns `led_o` on. A read of EEh turns it off.
- R13: A read of offset FEh returns flag 6 in bit 7 and zeros elsewhere. Any read of an offset not listed here returns 00h, and `rdata_o` is 00h whenever `rd_i` is low.

Top module port list order follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_evt_i | input | 8 | Source event inputs, rising edge sets flag |
| src_ack_i | input | 8 | Device-side clear pulses, one per source |
| tick_i | input | 1 | System tick event |
| par_err_i | input | 1 | Memory parity error event |
| io_err_i | input | 1 | I/O error event |
| chg_lvl_i | input | 2 | Live floppy change-line levels, drive 0 in bit 0 |
| addr_i | input | 8 | Register offset |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wr_i | input | 1 | Write strobe, one cycle per access |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from offset |
| irq0_o | output | 1 | Tick interrupt request |
| irq1_o | output | 1 | First shared interrupt request |
| irq2_o | output | 1 | Second shared interrupt request |
| nmi_o | output | 1 | Non-maskable interrupt request |
| led_o | output | 1 | Diagnostic LED |

## Verification
The bench targets the points where clears depend on access direction. Reading E6h must clear the DMA flag but leave keyboard transmit pending, and a design with the directions swapped clears the wrong line. It drives an event rising edge in the same cycle as its clearing read to catch a clear-priority flag, which would drop a pending interrupt. It holds events high for several cycles to catch level-set flags that reassert right after a clear. It checks the mixed polarity of the source register, the change-line clear bit mapping (including a write that must clear only the other drive), and that the I/O-error flag survives the parity clear while the NMI gate tracks both flags.

// File: rtl/mb_irq_pkg.sv
package mb_irq_pkg;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int N_SRC = 8;
  localparam int N_DRV = 2;
  localparam int N_IRQ1 = 3;   // sources 0..N_IRQ1-1 drive irq1
  localparam int N_ALOW = 4;   // sources 0..N_ALOW-1 read back active low

  localparam int SRC_TMR2 = 0;
  localparam int SRC_DMA  = 3;
  localparam int SRC_KTX  = 4;
  localparam int SRC_FDC  = 6;

  localparam logic [7:0] OFS_CHG_CTL = 8'h00;
  localparam logic [7:0] OFS_SRC     = 8'h22;
  localparam logic [7:0] OFS_STAT    = 8'hE0;
  localparam logic [7:0] OFS_TMR2    = 8'hE2;
  localparam logic [7:0] OFS_LED_ON  = 8'hE4;
  localparam logic [7:0] OFS_KB_DMA  = 8'hE6;
  localparam logic [7:0] OFS_PAR_LED = 8'hEE;
  localparam logic [7:0] OFS_ID      = 8'hFE;

  localparam int CHG_CLR_LSB = 2;  // write bit 2 -> drive 0, bit 3 -> drive 1
endpackage

// File: rtl/mb_irq_flag.sv
module mb_irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic clr_i,
  output logic flag_o
);
  logic evt_q;
  logic rise;

  assign rise = evt_i & ~evt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q  <= 1'b0;
      flag_o <= 1'b0;
    end else begin
      evt_q <= evt_i;
      if (rise)       flag_o <= 1'b1;  // set beats clear
      else if (clr_i) flag_o <= 1'b0;
    end
  end

  p_rise_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && !evt_q) |=> flag_o);
  p_set_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && !evt_q && clr_i) |=> flag_o);
  p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !(evt_i && !evt_q)) |=> !flag_o);
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);
endmodule

// File: rtl/mb_irq_chg.sv
module mb_irq_chg #(
  parameter int N_DRV = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_DRV-1:0] lvl_i,
  input  logic [N_DRV-1:0] clr_i,
  output logic [N_DRV-1:0] chg_o
);
  logic primed_q;
  logic [N_DRV-1:0] lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      primed_q <= 1'b0;
      lvl_q    <= '0;
    end else begin
      primed_q <= 1'b1;
      lvl_q    <= lvl_i;
    end
  end

  for (genvar d = 0; d < N_DRV; d++) begin : g_drv
    logic toggled;
    assign toggled = primed_q & (lvl_i[d] ^ lvl_q[d]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         chg_o[d] <= 1'b0;
      else if (toggled)    chg_o[d] <= 1'b1;
      else if (clr_i[d])   chg_o[d] <= 1'b0;
    end

    p_chg_latch_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (primed_q && (lvl_i[d] != lvl_q[d])) |=> chg_o[d]);
  end
endmodule

// File: rtl/mb_irq_collector.sv
module mb_irq_collector
  import mb_irq_pkg::*;
#(
  parameter int ADDR_W = AW,
  parameter int DATA_W = DW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_evt_i,
  input  logic [N_SRC-1:0]  src_ack_i,
  input  logic              tick_i,
  input  logic              par_err_i,
  input  logic              io_err_i,
  input  logic [N_DRV-1:0]  chg_lvl_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq0_o,
  output logic              irq1_o,
  output logic              irq2_o,
  output logic              nmi_o,
  output logic              led_o
);
  function automatic logic at(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  logic rd_tmr2, rd_kb_dma, wr_kb_dma, wr_stat, wr_par, rd_par, rd_led, wr_tmr2, wr_chg;
  assign rd_tmr2   = rd_i & at(addr_i, OFS_TMR2);
  assign wr_tmr2   = wr_i & at(addr_i, OFS_TMR2);
  assign rd_kb_dma = rd_i & at(addr_i, OFS_KB_DMA);
  assign wr_kb_dma = wr_i & at(addr_i, OFS_KB_DMA);
  assign wr_stat   = wr_i & at(addr_i, OFS_STAT);
  assign rd_par    = rd_i & at(addr_i, OFS_PAR_LED);
  assign wr_par    = wr_i & at(addr_i, OFS_PAR_LED);
  assign rd_led    = rd_i & at(addr_i, OFS_LED_ON);
  assign wr_chg    = wr_i & at(addr_i, OFS_CHG_CTL);

  // source flags
  logic [N_SRC-1:0] src_clr, pend;
  for (genvar k = 0; k < N_SRC; k++) begin : g_src
    logic sw_clr;
    if (k == SRC_TMR2)     begin : g_c assign sw_clr = rd_tmr2;   end
    else if (k == SRC_DMA) begin : g_c assign sw_clr = rd_kb_dma; end
    else if (k == SRC_KTX) begin : g_c assign sw_clr = wr_kb_dma; end
    else                   begin : g_c assign sw_clr = 1'b0;      end
    assign src_clr[k] = sw_clr | src_ack_i[k];

    mb_irq_flag u_flag (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .evt_i (src_evt_i[k]),
      .clr_i (src_clr[k]),
      .flag_o(pend[k])
    );
  end

  // tick, parity, io error
  logic par_q, io_q;
  mb_irq_flag u_tick (.clk_i(clk_i), .rst_ni(rst_ni), .evt_i(tick_i),
                      .clr_i(wr_stat), .flag_o(irq0_o));
  mb_irq_flag u_par  (.clk_i(clk_i), .rst_ni(rst_ni), .evt_i(par_err_i),
                      .clr_i(wr_par), .flag_o(par_q));
  mb_irq_flag u_io   (.clk_i(clk_i), .rst_ni(rst_ni), .evt_i(io_err_i),
                      .clr_i(1'b0), .flag_o(io_q));

  // change lines
  logic [N_DRV-1:0] chg_q;
  logic [N_DRV-1:0] chg_clr;
  assign chg_clr = {N_DRV{wr_chg}} & wdata_i[CHG_CLR_LSB +: N_DRV];

  mb_irq_chg #(.N_DRV(N_DRV)) u_chg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (chg_lvl_i),
    .clr_i (chg_clr),
    .chg_o (chg_q)
  );

  // nmi enable and led
  logic nmi_en_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_en_q <= 1'b0;
      led_o    <= 1'b0;
    end else begin
      if (wr_tmr2) nmi_en_q <= wdata_i[0];
      if (rd_led)      led_o <= 1'b1;
      else if (rd_par) led_o <= 1'b0;
    end
  end

  assign nmi_o  = nmi_en_q & (par_q | io_q);
  assign irq1_o = |pend[N_IRQ1-1:0];
  assign irq2_o = |pend[N_SRC-1:N_IRQ1];

  // read data
  logic [7:0] src_view, stat_view, id_view;
  assign src_view  = {pend[N_SRC-1:N_ALOW], ~pend[N_ALOW-1:0]};
  assign stat_view = {chg_lvl_i, chg_q, pend[SRC_FDC], 1'b0, ~io_q, ~par_q};
  assign id_view   = {pend[SRC_FDC], 7'b0};

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      if (at(addr_i, OFS_SRC))       rdata_o = DATA_W'(src_view);
      else if (at(addr_i, OFS_STAT)) rdata_o = DATA_W'(stat_view);
      else if (at(addr_i, OFS_ID))   rdata_o = DATA_W'(id_view);
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  p_led_on_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_led |=> led_o);
  p_led_off_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_par |=> !led_o);
  p_nmi_off_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_tmr2 && !wdata_i[0]) |=> !nmi_o);
  p_io_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_q |=> io_q);
  p_idle_read_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> (rdata_o == '0));
endmodule

// File: tb/sim_mb_irq_collector.sv
module sim_mb_irq_collector;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] src_evt = '0, src_ack = '0;
  logic tick = 0, par_err = 0, io_err = 0;
  logic [1:0] chg = '0;
  logic [7:0] addr = '0, wdata = '0;
  logic rd = 0, wr = 0;
  logic [7:0] rdata;
  logic irq0, irq1, irq2, nmi, led;

  int n_chk = 0, n_err = 0;
  logic [7:0] pend = '0;

  always #4 clk = ~clk;

  mb_irq_collector u0 (
    .clk_i(clk), .rst_ni(rst_n), .src_evt_i(src_evt), .src_ack_i(src_ack),
    .tick_i(tick), .par_err_i(par_err), .io_err_i(io_err), .chg_lvl_i(chg),
    .addr_i(addr), .rd_i(rd), .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata),
    .irq0_o(irq0), .irq1_o(irq1), .irq2_o(irq2), .nmi_o(nmi), .led_o(led)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1; #1; d = rdata;
    @(negedge clk); rd = 0;
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic pulse_src(input int k, input int len);
    @(negedge clk); src_evt[k] = 1;
    repeat (len) @(negedge clk);
    src_evt[k] = 0;
    pend[k] = 1;
  endtask

  task automatic ack_src(input int k);
    @(negedge clk); src_ack[k] = 1;
    @(negedge clk); src_ack[k] = 0;
    pend[k] = 0;
  endtask

  function automatic logic [7:0] src_exp();
    return {pend[7:4], ~pend[3:0]};
  endfunction

  task automatic chk_src(input string tag);
    logic [7:0] d;
    rd_reg(8'h22, d);
    chk({tag, " R3 src reg"}, d, src_exp());
    chk({tag, " R4 irq1"}, {7'b0, irq1}, {7'b0, |pend[2:0]});
    chk({tag, " R4 irq2"}, {7'b0, irq2}, {7'b0, |pend[7:3]});
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 irq0", {7'b0, irq0}, 8'h00);
    chk("R1 irq1/2", {6'b0, irq1, irq2}, 8'h00);
    chk("R1 nmi/led", {6'b0, nmi, led}, 8'h00);
    rd_reg(8'h22, d); chk("R1 src reg", d, 8'h0F);
    rd_reg(8'hE0, d); chk("R1 status", d, 8'h03);
    rd_reg(8'hFE, d); chk("R1 id reg", d, 8'h00);
    chk("R13 idle rdata", rdata, 8'h00);
  endtask

  task automatic t_sources();
    logic [7:0] d;
    for (int k = 0; k < 8; k++) begin
      pulse_src(k, (k % 2) ? 4 : 1);   // R2 held-high events set once
      chk_src("R2");
    end
    rd_reg(8'hFE, d); chk("R13 id fdc pending", d, 8'h80);
    // R5 directional clears
    rd_reg(8'hE6, d); pend[3] = 0; chk_src("R5 rd E6");
    wr_reg(8'hE6, 8'h00); pend[4] = 0; chk_src("R5 wr E6");
    rd_reg(8'hE2, d); pend[0] = 0; chk_src("R5 rd E2");
    for (int k = 1; k < 8; k++) begin
      if (k == 3 || k == 4) continue;
      ack_src(k);
    end
    chk_src("R5 ack");
    // R2 re-arm needs a new rising edge
    @(negedge clk); src_evt[5] = 1;
    @(negedge clk); src_ack[5] = 1;
    @(negedge clk); src_ack[5] = 0;
    @(negedge clk); src_evt[5] = 0;
    chk_src("R2 no re-set while held");
  endtask

  task automatic t_set_wins();
    @(negedge clk); src_evt[0] = 1; addr = 8'hE2; rd = 1;
    @(negedge clk); rd = 0; src_evt[0] = 0;
    pend[0] = 1;
    chk_src("R6 set beats rd E2");
    @(negedge clk); src_evt[4] = 1; addr = 8'hE6; wdata = 0; wr = 1;
    @(negedge clk); wr = 0; src_evt[4] = 0;
    pend[4] = 1;
    chk_src("R6 set beats wr E6");
    ack_src(0); ack_src(4);
    chk_src("R6 cleanup");
  endtask

  task automatic t_tick();
    logic [7:0] d;
    @(negedge clk); tick = 1; @(negedge clk); tick = 0;
    chk("R7 tick set", {7'b0, irq0}, 8'h01);
    rd_reg(8'hE0, d);
    chk("R7 read keeps", {7'b0, irq0}, 8'h01);
    wr_reg(8'hE0, 8'h00);
    chk("R7 write clears", {7'b0, irq0}, 8'h00);
  endtask

  task automatic t_errors();
    logic [7:0] d;
    @(negedge clk); par_err = 1; @(negedge clk); par_err = 0;
    rd_reg(8'hE0, d); chk("R8 parity bit", d, 8'h02);
    chk("R11 nmi disabled", {7'b0, nmi}, 8'h00);
    wr_reg(8'hE2, 8'h01);
    chk("R11 nmi enabled", {7'b0, nmi}, 8'h01);
    wr_reg(8'hEE, 8'h00);
    rd_reg(8'hE0, d); chk("R10 parity cleared", d, 8'h03);
    chk("R11 nmi follows", {7'b0, nmi}, 8'h00);
    @(negedge clk); io_err = 1; @(negedge clk); io_err = 0;
    chk("R11 nmi io", {7'b0, nmi}, 8'h01);
    wr_reg(8'hEE, 8'h00);
    rd_reg(8'hE0, d); chk("R10 io sticky", d, 8'h01);
    wr_reg(8'hE2, 8'h00);
    chk("R11 nmi off", {7'b0, nmi}, 8'h00);
  endtask

  task automatic t_chg();
    logic [7:0] d;
    @(negedge clk); chg[0] = 1;
    rd_reg(8'hE0, d); chk("R9 drv0 change", d, 8'h51);
    wr_reg(8'h00, 8'hF3);
    rd_reg(8'hE0, d); chk("R9 other bits ignored", d, 8'h51);
    wr_reg(8'h00, 8'h08);
    rd_reg(8'hE0, d); chk("R9 drv1 clear leaves drv0", d, 8'h51);
    wr_reg(8'h00, 8'h04);
    rd_reg(8'hE0, d); chk("R9 drv0 clear", d, 8'h41);
    @(negedge clk); chg[1] = 1; @(negedge clk); chg[1] = 0;
    rd_reg(8'hE0, d); chk("R9 drv1 pulse", d, 8'h61);
    pulse_src(6, 1);
    rd_reg(8'hE0, d); chk("R8 fdc bit", d, 8'h69);
    wr_reg(8'h00, 8'h0C); ack_src(6);
    rd_reg(8'hE0, d); chk("R8 cleared", d, 8'h41);
  endtask

  task automatic t_led();
    logic [7:0] d;
    rd_reg(8'hE4, d);
    chk("R12 led on", {7'b0, led}, 8'h01);
    rd_reg(8'h50, d);
    chk("R13 unmapped read", d, 8'h00);
    chk("R13 led kept", {7'b0, led}, 8'h01);
    rd_reg(8'hEE, d);
    chk("R12 led off", {7'b0, led}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_sources();
    t_set_wins();
    t_tick();
    t_errors();
    t_chg();
    t_led();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #800000;
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule